// File: doc/BRIEF.md
# Third-Order Fractional Sigma-Delta Interpolator

This block turns a fraction numerator over a programmable modulus into a stream of small signed integer steps, one per phase-detector cycle. A fractional-N divider adds each step to its integer ratio, so over time the divider's average ratio carries the exact fraction. Three cascaded accumulators each wrap at the modulus. Their carries are combined into a noise-shaping output in the range −3 to +4.

A frequency-write strobe captures the fraction, modulus and dither choice. The restart control decides what that write does to the accumulators. When the control is 0, the first accumulator is preloaded from a phase word and everything else is cleared, so a given channel always begins from the same point in its sequence. When the control is 1, the running state carries on. An optional pseudo-random dither lengthens the repeat cycle. Dither only acts for moduli of at least 50.

The controller has two states. ST_IDLE is entered at reset. In it the block holds still and outputs zero. The ARM transition (a write while in ST_IDLE) leads to ST_RUN. In ST_RUN the modulator advances on every cycle that carries no write. A write in ST_RUN is the RELOAD transition, which stays in ST_RUN. Reset returns the controller to ST_IDLE from either state.

Top module: `mash3_frac_sdm`

## Requirements
- R1: After reset, and in every cycle until the first frequency write, step_out is 0 and no input other than freq_wr has any effect on it.
- R2: At a write, a modulus below 2 is taken as 2, a fraction not below the modulus is taken as modulus−1, and a phase word not below the modulus is taken as 0.
- R3: On each cycle in ST_RUN without a write, the three stages update in order: a1=(a1+F+d) mod M, then a2=(a2+a1) mod M, then a3=(a3+a2) mod M. Each stage gives carry c1, c2 or c3 when its sum reaches M. One cycle later step_out = c1 + c2 − c2' + c3 − 2·c3' + c3'', where ' means the value one advance earlier and '' two advances earlier. step_out always lies in −3..+4.
- R4: With dither off, the sum of step_out over any full repeat length L (taken after the first four advance cycles) equals F·L/M.
- R5: With dither off, the sequence repeats with length L: L = 6M if M is divisible by 6, 2M if M is even and not a multiple of 3, 3M if M is a multiple of 3 and odd, and M otherwise.
- R6: A write with keep_phase=0 loads a1 with the phase word and clears a2, a3, all carry history and the dither generator (seed 1). step_out is 0 in the cycle after the write.
- R7: A write with keep_phase=1 keeps the accumulators and carry history, except that an accumulator not below the new modulus becomes 0. step_out is 0 in the cycle after the write, and no advance happens on a write cycle.
- R8: Dither comes from a 21-bit shift register s. It shifts left on each advance, taking in s[20] XOR s[18]. The bit d = s[20] is added to the first-stage input, but only when dither is enabled and M ≥ 50. Otherwise the sequence is the same as with dither off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_wr | input | 1 | Frequency-write strobe, one cycle |
| frac_num | input | 12 | Fraction numerator F |
| modulus | input | 12 | Modulus M (2..4095) |
| phase_word | input | 12 | Starting value for the first accumulator |
| dither_en | input | 1 | Dither enable |
| keep_phase | input | 1 | 0: restart from phase word on write; 1: continue |
| step_out | output | 4 | Signed divider increment, −3..+4 |

## Verification
Two functions can act in the same cycle. The first case is the dither bit landing on a first stage whose fraction is already M−1: the stage input then equals the modulus, and the wrap must still give a single carry and a remainder below M. The bench provokes this with F=59, M=60 and dither on, and compares every output against an independent model of the recurrence. The second case is a keep-phase write that shrinks the modulus below a live accumulator value, so that capture and clamping coincide. Both the zero output that follows and the later sequence are judged against the model.

// File: rtl/mash3_pkg.sv
package mash3_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sdm_state_e;

    localparam int STEP_MIN = -3;
    localparam int STEP_MAX = 4;
endpackage

// File: rtl/mash3_lfsr.sv
module mash3_lfsr #(
    parameter int LEN   = 21,
    parameter int TAP_A = 20,
    parameter int TAP_B = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_ld,
    input  logic adv,
    output logic bit_out
);
    localparam logic [LEN-1:0] SEED = LEN'(1);

    logic [LEN-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= SEED;
        else if (seed_ld)
            sr_q <= SEED;
        else if (adv)
            sr_q <= {sr_q[LEN-2:0], sr_q[TAP_A] ^ sr_q[TAP_B]};
    end

    assign bit_out = sr_q[LEN-1];

    // R8
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);
endmodule

// File: rtl/mash3_stage.sv
module mash3_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         wr,
    input  logic         preset_en,
    input  logic [W-1:0] preset_val,
    input  logic [W:0]   inc,
    input  logic [W-1:0] mod_run,
    input  logic [W-1:0] mod_new,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] acc_nxt,
    output logic         carry_nxt
);
    logic [W:0] sum;

    always_comb begin
        sum       = {1'b0, acc_q} + inc;
        carry_nxt = (sum >= {1'b0, mod_run});
        acc_nxt   = carry_nxt ? W'(sum - {1'b0, mod_run}) : sum[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (wr)
            acc_q <= preset_en ? preset_val : ((acc_q >= mod_new) ? '0 : acc_q);
        else if (adv)
            acc_q <= acc_nxt;
    end

    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < mod_run);
endmodule

// File: rtl/mash3_frac_sdm.sv
module mash3_frac_sdm #(
    parameter int MOD_W      = 12,
    parameter int OUT_W      = 4,
    parameter int DITHER_MIN = 50,
    parameter int LFSR_LEN   = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    freq_wr,
    input  logic [MOD_W-1:0]        frac_num,
    input  logic [MOD_W-1:0]        modulus,
    input  logic [MOD_W-1:0]        phase_word,
    input  logic                    dither_en,
    input  logic                    keep_phase,
    output logic signed [OUT_W-1:0] step_out
);
    import mash3_pkg::*;

    localparam int NSTG = 3;
    localparam logic [MOD_W-1:0] MOD_FLOOR = MOD_W'(2);
    localparam logic [MOD_W-1:0] DITH_MOD  = MOD_W'(DITHER_MIN);

    sdm_state_e state_q, state_d;

    logic [MOD_W-1:0] mod_q, frac_q;
    logic             dith_q;
    logic             c2_d1, c3_d1, c3_d2;
    logic [OUT_W-1:0] step_q, y_sum;

    logic [MOD_W-1:0] mod_eff, frac_eff, phase_eff;
    logic             adv, restart, dith_bit, lfsr_bit;

    logic [MOD_W:0]   inc     [NSTG];
    logic [MOD_W-1:0] acc_q   [NSTG];
    logic [MOD_W-1:0] acc_nxt [NSTG];
    logic             carry   [NSTG];

    always_comb begin
        mod_eff   = (modulus < MOD_FLOOR) ? MOD_FLOOR : modulus;
        frac_eff  = (frac_num >= mod_eff) ? (mod_eff - MOD_W'(1)) : frac_num;
        phase_eff = (phase_word >= mod_eff) ? '0 : phase_word;
    end

    assign adv      = (state_q == ST_RUN) && !freq_wr;
    assign restart  = freq_wr && !keep_phase;
    assign dith_bit = dith_q && (mod_q >= DITH_MOD) && lfsr_bit;

    mash3_lfsr #(.LEN(LFSR_LEN), .TAP_A(LFSR_LEN-1), .TAP_B(LFSR_LEN-3)) u_dith (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_ld (restart),
        .adv     (adv),
        .bit_out (lfsr_bit)
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign inc[g] = {1'b0, frac_q} + {{MOD_W{1'b0}}, dith_bit};
        end else begin : g_tail
            assign inc[g] = {1'b0, acc_nxt[g-1]};
        end

        mash3_stage #(.W(MOD_W)) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv        (adv),
            .wr         (freq_wr),
            .preset_en  (!keep_phase),
            .preset_val ((g == 0) ? phase_eff : '0),
            .inc        (inc[g]),
            .mod_run    (mod_q),
            .mod_new    (mod_eff),
            .acc_q      (acc_q[g]),
            .acc_nxt    (acc_nxt[g]),
            .carry_nxt  (carry[g])
        );
    end

    // noise-shaping recombination of the three carries
    assign y_sum = OUT_W'(carry[0])
                 + OUT_W'(carry[1]) - OUT_W'(c2_d1)
                 + OUT_W'(carry[2]) - (OUT_W'(c3_d1) << 1) + OUT_W'(c3_d2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (freq_wr) state_d = ST_RUN;   // ARM
            ST_RUN:  state_d = ST_RUN;                // RELOAD or advance
            default: state_d = ST_IDLE;
        endcase
    end

    // output and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q  <= MOD_FLOOR;
            frac_q <= '0;
            dith_q <= 1'b0;
            c2_d1  <= 1'b0;
            c3_d1  <= 1'b0;
            c3_d2  <= 1'b0;
            step_q <= '0;
        end else if (freq_wr) begin
            mod_q  <= mod_eff;
            frac_q <= frac_eff;
            dith_q <= dither_en;
            step_q <= '0;
            if (!keep_phase) begin
                c2_d1 <= 1'b0;
                c3_d1 <= 1'b0;
                c3_d2 <= 1'b0;
            end
        end else if (adv) begin
            step_q <= y_sum;
            c2_d1  <= carry[1];
            c3_d1  <= carry[2];
            c3_d2  <= c3_d1;
        end
    end

    assign step_out = $signed(step_q);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (step_out == '0));

    // R3
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(step_out) >= STEP_MIN) && (int'(step_out) <= STEP_MAX));

    // R6
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (step_out == '0) && (acc_q[0] == $past(phase_eff))
                    && !c2_d1 && !c3_d1 && !c3_d2);

    // R7
    keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_wr && keep_phase) |=> $stable(c3_d1) && $stable(c3_d2)
                                    && (step_out == '0));

    // R8
    dither_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_q < DITH_MOD || !dith_q) |-> (inc[0] == {1'b0, frac_q}));
endmodule

// File: tb/mash3_frac_sdm_test.sv
module mash3_frac_sdm_test;
    localparam int CLK_P = 10;
    localparam int NVEC  = 5;
    // fields: modulus, fraction, phase, repeat length
    localparam logic [47:0] VEC [NVEC] = '{
        {12'd7,  12'd3,  12'd0, 12'd7},
        {12'd10, 12'd3,  12'd5, 12'd20},
        {12'd9,  12'd2,  12'd1, 12'd27},
        {12'd12, 12'd5,  12'd0, 12'd72},
        {12'd50, 12'd49, 12'd7, 12'd100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic freq_wr = 1'b0;
    logic [11:0] frac_num = '0, modulus = '0, phase_word = '0;
    logic dither_en = 1'b0, keep_phase = 1'b0;
    logic signed [3:0] step_out;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // independent model state
    int m_mod = 2, m_frac = 0, m_out = 0;
    int m_a [3] = '{0, 0, 0};
    int m_c2d = 0, m_c3d = 0, m_c3dd = 0;
    bit m_run = 0, m_dith = 0;
    logic [20:0] m_sr = 21'h1;

    int hist  [0:255];
    int hist2 [0:255];

    always #(CLK_P/2) clk = ~clk;

    mash3_frac_sdm uut (
        .clk(clk), .rst_n(rst_n), .freq_wr(freq_wr), .frac_num(frac_num),
        .modulus(modulus), .phase_word(phase_word), .dither_en(dither_en),
        .keep_phase(keep_phase), .step_out(step_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge(input bit wr, input int f, input int m, input int p,
                              input bit dn, input bit kp);
        int me, s, c [3], d;
        if (wr) begin
            me = (m < 2) ? 2 : m;
            if (!kp) begin
                m_a[0] = (p >= me) ? 0 : p;
                m_a[1] = 0; m_a[2] = 0;
                m_c2d = 0; m_c3d = 0; m_c3dd = 0;
                m_sr = 21'h1;
            end else begin
                for (int i = 0; i < 3; i++) if (m_a[i] >= me) m_a[i] = 0;
            end
            m_mod = me;
            m_frac = (f >= me) ? me - 1 : f;
            m_dith = dn;
            m_out = 0;
            m_run = 1;
        end else if (m_run) begin
            d = (m_dith && m_mod >= 50 && m_sr[20]) ? 1 : 0;
            for (int i = 0; i < 3; i++) begin
                s = m_a[i] + ((i == 0) ? (m_frac + d) : m_a[i-1]);
                c[i] = (s >= m_mod) ? 1 : 0;
                m_a[i] = c[i] ? s - m_mod : s;
            end
            m_out = c[0] + c[1] - m_c2d + c[2] - 2 * m_c3d + m_c3dd;
            m_c3dd = m_c3d;
            m_c2d = c[1];
            m_c3d = c[2];
            m_sr = {m_sr[19:0], m_sr[20] ^ m_sr[18]};
        end
    endtask

    // drive at negedge, let one rising edge pass, return at next negedge
    task automatic cyc(input bit wr, input int f, input int m, input int p,
                       input bit dn, input bit kp);
        freq_wr = wr; frac_num = 12'(f); modulus = 12'(m);
        phase_word = 12'(p); dither_en = dn; keep_phase = kp;
        model_edge(wr, f, m, p, dn, kp);
        @(posedge clk);
        @(negedge clk);
    endtask

    // run n advance cycles, compare every output with the model
    task automatic run(input int n, input string req, input bit alt);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            cyc(0, 0, 0, 0, 0, 0);
            if (alt) hist2[k] = int'(step_out); else hist[k] = int'(step_out);
            if (int'(step_out) != m_out || int'(step_out) < -3 || int'(step_out) > 4) begin
                if (bad == 0)
                    $display("FAIL %s cycle %0d actual=%0d expected=%0d",
                             req, k, int'(step_out), m_out);
                bad++;
            end
        end
        n_tests++;
        if (bad != 0) n_fail++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int mm, ff, pp, ll, sum, bad;
        repeat (3) @(negedge clk);
        check("R1 reset output", int'(step_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: inputs move but no write: output stays 0
        for (int k = 0; k < 6; k++) begin
            cyc(0, 5, 11, 3, k[0], k[1]);
            check("R1 idle no write", int'(step_out), 0);
        end

        // table of vectors, dither off, restart writes
        for (int v = 0; v < NVEC; v++) begin
            mm = int'(VEC[v][47:36]); ff = int'(VEC[v][35:24]);
            pp = int'(VEC[v][23:12]); ll = int'(VEC[v][11:0]);
            cyc(1, ff, mm, pp, 0, 0);
            check("R6 zero after restart write", int'(step_out), 0);
            run(4 + 2 * ll, "R3 sequence", 0);
            bad = 0;
            for (int n = 4; n < 4 + ll; n++) if (hist[n] != hist[n + ll]) bad++;
            check("R5 repeat length mismatches", bad, 0);
            sum = 0;
            for (int n = 4; n < 4 + ll; n++) sum += hist[n];
            check("R4 average over repeat", sum, ff * ll / mm);
        end

        // R2: clamping of modulus, fraction and phase
        cyc(1, 9, 1, 5, 0, 0);
        check("R2 zero after write", int'(step_out), 0);
        run(12, "R2 clamped sequence", 0);
        sum = 0;
        for (int n = 4; n < 8; n++) sum += hist[n];
        check("R2 clamped average", sum, 2);

        // R7: keep-phase write shrinking the modulus
        cyc(1, 5, 12, 11, 0, 0);
        run(9, "R7 pre-keep run", 0);
        cyc(1, 3, 8, 0, 0, 1);
        check("R7 zero after keep write", int'(step_out), 0);
        run(24, "R7 continued sequence", 0);

        // R6: restart from a different phase word
        cyc(1, 4, 13, 6, 0, 0);
        run(30, "R6 phase preset sequence", 0);

        // R8: dither at full fraction, input reaches modulus
        cyc(1, 59, 60, 3, 1, 0);
        run(300, "R8 dithered sequence", 0);

        // R8: dither requested below 50 has no effect
        cyc(1, 13, 40, 2, 1, 0);
        run(80, "R8 gated dither", 0);
        cyc(1, 13, 40, 2, 0, 0);
        run(80, "R8 plain reference", 1);
        bad = 0;
        for (int n = 0; n < 80; n++) if (hist[n] != hist2[n]) bad++;
        check("R8 low-modulus dither ignored", bad, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule